// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that fetches, decodes and retires one instruction on every rising clock edge. It executes a fixed subset of seven operations: register add and subtract, OR with an immediate, word load, word store, branch when two registers match, and an absolute jump. Every other encoding is treated as a no-op.

The core contains the program counter and its next-address logic, a control decoder, a register file with two read ports and one write port, a small ALU, an immediate extender, and two internal word arrays. One array holds instructions and the other holds data. The instruction array has no write port. A test environment fills it by hierarchical assignment before reset is released.

The core exposes only the current PC and the most recent register write, so that an outside model can follow execution step by step.

Top module: `sc7_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and `dbg_wr_en` becomes 0.
- R2: Opcode 000000 (bits 31:26) with funct 100000 (bits 5:0) writes rs+rt to rd, and with funct 100010 writes rs-rt to rd. The field positions are rs at bits 25:21, rt at bits 20:16 and rd at bits 15:11.
- R3: Opcode 001101 writes the OR of rs and the zero-extended 16-bit immediate (bits 15:0) to rt.
- R4: Opcode 100011 writes to rt the data word at byte address rs plus the sign-extended immediate.
- R5: Opcode 101011 stores rt at byte address rs plus the sign-extended immediate, and writes no register.
- R6: Opcode 000100 sets the PC to PC+4+(sign-extended immediate shifted left by 2) when rs equals rt, and to PC+4 otherwise.
- R7: Opcode 000010 sets the PC to {PC+4 bits 31:28, bits 25:0 of the instruction, 2'b00}.
- R8: Register 0 always reads as zero, and a write to it has no effect and is not reported.
- R9: Any other opcode, and opcode 000000 with any other funct, writes nothing and advances the PC by 4.
- R10: After every edge that writes a non-zero register, `dbg_wr_en` is 1 for one cycle, with that register's index on `dbg_wr_addr` and the value on `dbg_wr_data`. After every other edge, `dbg_wr_en` is 0.
- R11: Every instruction other than a branch or jump advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pc | output | 32 | Address of the instruction being executed this cycle |
| dbg_wr_en | output | 1 | A register was written at the previous edge |
| dbg_wr_addr | output | 5 | Index of the register last written |
| dbg_wr_data | output | 32 | Value last written |

## Verification
The assertions take it for granted that the instruction array holds a known word at every address the PC can reach. They also assume that the PC only ever comes from reset or from the next-address logic, so its low two bits stay zero. The stimulus loads a complete program during reset and fills every unused word with zero, which decodes as a no-op. The same program is mirrored in the bench, so any fetch lands on a defined word. Store and load addresses in the program stay inside the data array, which keeps data accesses free of wrap-around.

// File: rtl/sc7_pkg.sv
package sc7_pkg;

    localparam int XLEN     = 32;
    localparam int REG_NUM  = 32;
    localparam int REG_IDXW = $clog2(REG_NUM);

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_ORI   = 6'b001101;
    localparam logic [5:0] OPC_LW    = 6'b100011;
    localparam logic [5:0] OPC_SW    = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;

    typedef enum logic [1:0] {
        PC_SEQ    = 2'b00,
        PC_BRANCH = 2'b01,
        PC_JUMP   = 2'b10
    } pc_sel_e;

    typedef struct packed {
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    imm_signed;
        logic    wb_from_mem;
        logic    reg_we;
        logic    mem_we;
        pc_sel_e pc_sel;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        logic [5:0] opcode;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } instr_fields_t;

    function automatic logic [XLEN-1:0] extend_imm(input logic [15:0] imm,
                                                   input logic sgn);
        return {{(XLEN-16){sgn & imm[15]}}, imm};
    endfunction

    function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] pc4,
                                                      input logic [15:0] imm);
        return pc4 + {extend_imm(imm, 1'b1), 2'b00} ;
    endfunction

    function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc4,
                                                    input logic [25:0] tgt);
        return {pc4[XLEN-1:XLEN-4], tgt, 2'b00};
    endfunction

endpackage

// File: rtl/sc7_decode.sv
module sc7_decode
    import sc7_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.pc_sel = PC_SEQ;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OPC_RTYPE: begin
                if (funct == FN_ADD || funct == FN_SUB) begin
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.reg_we    = 1'b1;
                    ctrl.alu_op    = (funct == FN_SUB) ? ALU_SUB : ALU_ADD;
                end
            end
            OPC_ORI: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.reg_we   = 1'b1;
                ctrl.alu_op   = ALU_OR;
            end
            OPC_LW: begin
                ctrl.b_is_imm    = 1'b1;
                ctrl.imm_signed  = 1'b1;
                ctrl.wb_from_mem = 1'b1;
                ctrl.reg_we      = 1'b1;
            end
            OPC_SW: begin
                ctrl.b_is_imm   = 1'b1;
                ctrl.imm_signed = 1'b1;
                ctrl.mem_we     = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.pc_sel = PC_BRANCH;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JUMP: begin
                ctrl.pc_sel = PC_JUMP;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc7_alu.sv
module sc7_alu
    import sc7_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         eq
);
    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end
    assign eq = (a == b);
endmodule

// File: rtl/sc7_regfile.sv
module sc7_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs_q[i] <= '0;
        end else if (we && wa != '0) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];
endmodule

// File: rtl/sc7_word_mem.sv
module sc7_word_mem #(
    parameter int W        = 32,
    parameter int WORDS    = 64,
    parameter bit WRITABLE = 1'b1,
    localparam int IW = $clog2(WORDS)
) (
    input  logic         clk,
    input  logic [W-1:0] addr,
    output logic [W-1:0] rdata,
    input  logic         we,
    input  logic [W-1:0] wdata
);
    logic [W-1:0] mem_q [WORDS];
    logic [IW-1:0] idx;

    assign idx   = addr[IW+1:2];
    assign rdata = mem_q[idx];

    generate
        if (WRITABLE) begin : g_rw
            always_ff @(posedge clk) begin
                if (we) mem_q[idx] <= wdata;
            end
        end else begin : g_ro
            initial begin
                for (int i = 0; i < WORDS; i++) mem_q[i] = '0;
            end
        end
    endgenerate

    logic unused_bits;
    assign unused_bits = ^{addr[W-1:IW+2], addr[1:0], we, wdata, clk};
endmodule

// File: rtl/sc7_core.sv
module sc7_core
    import sc7_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] dbg_pc,
    output logic            dbg_wr_en,
    output logic [4:0]      dbg_wr_addr,
    output logic [XLEN-1:0] dbg_wr_data
);
    logic [XLEN-1:0] pc_q, pc_d, pc_plus4;
    logic [XLEN-1:0] instr;
    instr_fields_t   f;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, mem_rdata, wb_val;
    logic            alu_eq;
    logic [REG_IDXW-1:0] dst;

    sc7_word_mem #(.W(XLEN), .WORDS(IMEM_WORDS), .WRITABLE(1'b0)) u_imem (
        .clk(clk), .addr(pc_q), .rdata(instr), .we(1'b0), .wdata('0)
    );

    assign f = instr_fields_t'(instr);

    sc7_decode u_dec (.opcode(f.opcode), .funct(f.funct), .ctrl(ctrl));

    assign dst = ctrl.dst_is_rd ? f.rd : f.rt;

    sc7_regfile #(.W(XLEN), .N(REG_NUM)) u_rf (
        .clk(clk), .rst(rst),
        .ra_a(f.rs), .ra_b(f.rt), .rd_a(rs_val), .rd_b(rt_val),
        .we(ctrl.reg_we), .wa(dst), .wd(wb_val)
    );

    assign imm_ext = extend_imm(instr[15:0], ctrl.imm_signed);
    assign alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;

    sc7_alu #(.W(XLEN)) u_alu (
        .a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .eq(alu_eq)
    );

    sc7_word_mem #(.W(XLEN), .WORDS(DMEM_WORDS), .WRITABLE(1'b1)) u_dmem (
        .clk(clk), .addr(alu_y), .rdata(mem_rdata),
        .we(ctrl.mem_we), .wdata(rt_val)
    );

    assign wb_val   = ctrl.wb_from_mem ? mem_rdata : alu_y;
    assign pc_plus4 = pc_q + 32'd4;

    always_comb begin
        unique case (ctrl.pc_sel)
            PC_BRANCH: pc_d = alu_eq ? branch_target(pc_plus4, instr[15:0]) : pc_plus4;
            PC_JUMP:   pc_d = jump_target(pc_plus4, instr[25:0]);
            default:   pc_d = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q        <= '0;
            dbg_wr_en   <= 1'b0;
            dbg_wr_addr <= '0;
            dbg_wr_data <= '0;
        end else begin
            pc_q      <= pc_d;
            dbg_wr_en <= ctrl.reg_we && (dst != '0);
            if (ctrl.reg_we && dst != '0) begin
                dbg_wr_addr <= dst;
                dbg_wr_data <= wb_val;
            end
        end
    end

    assign dbg_pc = pc_q;

    logic unused_fields;
    assign unused_fields = ^{f.shamt};
endmodule

// File: rtl/sc7_core_chk.sv
module sc7_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic        rf_we,
    input logic        dm_we,
    input logic        wr_en_o
);
    logic [5:0] opc;
    logic       known;
    assign opc   = instr[31:26];
    assign known = (opc == 6'b000000 && (instr[5:0] == 6'b100000 || instr[5:0] == 6'b100010))
                || opc == 6'b001101 || opc == 6'b100011 || opc == 6'b101011
                || opc == 6'b000100 || opc == 6'b000010;

    a_r1_reset_pc: assert property (@(posedge clk) rst |=> (pc == 32'd0 && !wr_en_o));

    a_r5_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
        dm_we |-> !rf_we);

    a_r9_unknown_noop: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!rf_we && !dm_we));

    a_r11_seq_step: assert property (@(posedge clk) disable iff (rst)
        (opc != 6'b000100 && opc != 6'b000010) |=> (pc == $past(pc) + 32'd4));

    a_r6_pc_aligned: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);
endmodule

bind sc7_core sc7_core_chk u_chk (
    .clk(clk), .rst(rst), .pc(pc_q), .instr(instr),
    .rf_we(ctrl.reg_we), .dm_we(ctrl.mem_we), .wr_en_o(dbg_wr_en)
);

// File: tb/sc7_core_tb.sv
module sc7_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dbg_pc, dbg_wr_data;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_addr;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sc7_core dut_i (
        .clk(clk), .rst(rst), .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en),
        .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data)
    );

    logic [31:0] prog [64];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [64];
    logic [31:0] m_pc;
    logic        e_en;
    logic [4:0]  e_addr;
    logic [31:0] e_data;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int word);
        return {6'b000010, 26'(word)};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at model pc %h: actual %h expected %h", tag, m_pc, act, exp);
        end
    endtask

    function automatic string tag_of(logic [31:0] ins);
        logic [5:0] op = ins[31:26];
        logic [5:0] fn = ins[5:0];
        if (op == 6'b000000 && (fn == 6'b100000 || fn == 6'b100010))
            return (ins[15:11] == 0) ? "R8" : "R2";
        if (op == 6'b001101) return (ins[20:16] == 0) ? "R8" : "R3";
        if (op == 6'b100011) return (ins[20:16] == 0) ? "R8" : "R4";
        if (op == 6'b101011) return "R5";
        if (op == 6'b000100) return "R6";
        if (op == 6'b000010) return "R7";
        return "R9";
    endfunction

    // Behavioural reference: one call per rising edge after reset.
    task automatic model_step(output string tag);
        logic [31:0] ins, a, b, pc4, nxt;
        logic [5:0]  op;
        int          dst;
        logic [31:0] val;
        bit          wr;
        logic [31:0] simm, zimm;
        ins  = prog[m_pc[7:2]];
        tag  = tag_of(ins);
        op   = ins[31:26];
        a    = m_reg[ins[25:21]];
        b    = m_reg[ins[20:16]];
        simm = {{16{ins[15]}}, ins[15:0]};
        zimm = {16'd0, ins[15:0]};
        pc4  = m_pc + 4;
        nxt  = pc4;
        wr   = 0;
        dst  = 0;
        val  = 0;
        case (op)
            6'b000000: begin
                if (ins[5:0] == 6'b100000) begin wr = 1; dst = ins[15:11]; val = a + b; end
                else if (ins[5:0] == 6'b100010) begin wr = 1; dst = ins[15:11]; val = a - b; end
            end
            6'b001101: begin wr = 1; dst = ins[20:16]; val = a | zimm; end
            6'b100011: begin wr = 1; dst = ins[20:16]; val = m_mem[(a + simm) >> 2]; end
            6'b101011: m_mem[(a + simm) >> 2] = b;
            6'b000100: if (a == b) nxt = pc4 + (simm << 2);
            6'b000010: nxt = {pc4[31:28], ins[25:0], 2'b00};
            default: ;
        endcase
        if (wr && dst != 0) begin
            m_reg[dst] = val;
            e_en = 1; e_addr = 5'(dst); e_data = val;
        end else begin
            e_en = 0;
        end
        m_pc = nxt;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        string t;
        for (int i = 0; i < 64; i++) prog[i] = 32'd0;
        prog[0]  = enc_i(6'b001101, 0, 1, 16'h1234);
        prog[1]  = enc_i(6'b001101, 0, 2, 16'hFFFF);
        prog[2]  = enc_r(1, 2, 3, 6'b100000);
        prog[3]  = enc_r(1, 2, 4, 6'b100010);
        prog[4]  = enc_i(6'b001101, 0, 6, 16'h0048);
        prog[5]  = enc_i(6'b101011, 6, 3, -8);
        prog[6]  = enc_i(6'b100011, 6, 7, -8);
        prog[7]  = enc_i(6'b001101, 0, 0, 5);
        prog[8]  = enc_r(0, 0, 8, 6'b100000);
        prog[9]  = {6'b111111, 26'h155AA};
        prog[10] = enc_r(1, 2, 9, 6'b100101);
        prog[11] = enc_i(6'b000100, 1, 1, 2);
        prog[12] = enc_i(6'b001101, 0, 13, 16'h0BAD);
        prog[13] = enc_i(6'b001101, 0, 13, 16'h0BAD);
        prog[14] = enc_i(6'b000100, 1, 2, 5);
        prog[15] = enc_j(20);
        for (int i = 16; i < 20; i++) prog[i] = enc_i(6'b001101, 0, 14, 16'hDEAD);
        prog[20] = enc_r(3, 1, 10, 6'b100000);
        prog[21] = enc_j(23);
        prog[22] = enc_i(6'b001101, 11, 11, 1);
        prog[23] = enc_i(6'b000100, 0, 0, -2);
        #1;
        for (int i = 0; i < 64; i++) dut_i.u_imem.mem_q[i] = prog[i];
        for (int i = 0; i < 32; i++) m_reg[i] = 0;
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
        m_pc = 0;
        e_en = 0; e_addr = 0; e_data = 0;

        repeat (3) @(negedge clk);
        check(dbg_pc == 0, "R1 pc", dbg_pc, 0);
        check(dbg_wr_en == 0, "R1 wr_en", 32'(dbg_wr_en), 0);
        rst = 1'b0;

        for (int s = 0; s < 70; s++) begin
            @(negedge clk);
            model_step(t);
            if (t == "R6" || t == "R7")
                check(dbg_pc == m_pc, {t, " pc"}, dbg_pc, m_pc);
            else
                check(dbg_pc == m_pc, {"R11/", t, " pc"}, dbg_pc, m_pc);
            check(dbg_wr_en == e_en, {"R10/", t, " wr_en"}, 32'(dbg_wr_en), 32'(e_en));
            if (e_en) begin
                check(dbg_wr_addr == e_addr, {"R10/", t, " wr_addr"}, 32'(dbg_wr_addr), 32'(e_addr));
                check(dbg_wr_data == e_data, {"R10/", t, " wr_data"}, dbg_wr_data, e_data);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule